// File: doc/BRIEF.md
# Register-Programmed Block Copy DMA

This block moves a run of bytes from one place in a 20-bit byte-addressed memory to another. Software sets it up through nine byte-wide registers: a source address, a destination address, a 16-bit byte count and a control byte. Writing the control byte with its go bit set starts the copy. For each byte, the engine issues one read on a simple request/acknowledge memory port, then one write of that byte to the destination. After each byte both addresses move one step in the chosen direction.

The addresses can walk upward or downward, so overlapping regions can be copied safely in either order. When the copy ends, the registers hold the progress. The count and control registers read zero. The low 16 bits of both addresses show the address just past the last byte moved. The high address bytes keep what software wrote. While a copy is running, the block ignores register writes and reports busy in control bit 7.

Top module: `blkcopy_dma`

## Requirements
- R1: After synchronous reset, every register reads 0x00, `busy` is low and `mem_req` is low.
- R2: Register offsets are: source bits 7:0 at 0, 15:8 at 1, 19:16 in bits 3:0 of offset 2. Destination bits 19:16 are in bits 3:0 of offset 3, bits 7:0 at 4, 15:8 at 5. Count low byte is at 6 and high byte at 7. Control is at 8. While idle, a write to offsets 0–7 reads back all 8 bits. A control write without bit 7 reads back bits 6:0, with bit 7 reading 0.
- R3: A write to control with bit 7 set and a nonzero count starts a copy. From the next cycle, `busy` is high and control bit 7 reads 1.
- R4: Each step reads one byte at the source address (`mem_we`=0) and then writes that byte to the destination address (`mem_we`=1). This repeats exactly count times. A later read sees bytes written earlier in the same copy.
- R5: Control bit 0 of the starting write picks the direction. With 0, both addresses increase by one after each byte. With 1, both decrease by one. Arithmetic wraps modulo 2^20.
- R6: The cycle after the last write is acknowledged, `busy` is low. Offsets 6, 7 and 8 then read 0x00. Offsets 0/1 and 4/5 hold the low 16 bits of the source and destination addresses that follow the last byte moved.
- R7: Completion leaves offsets 2 and 3 unchanged.
- R8: A start with a count of 0 makes no memory access and never raises `busy`. Control reads 0x00 from the next cycle.
- R9: While `busy` is high, register writes are ignored, including a second start.
- R10: Once raised, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack` is seen. While idle, `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_off | input | 4 | Register write offset |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_off | input | 4 | Register read offset |
| reg_rd_data | output | 8 | Register read data (combinational) |
| busy | output | 1 | Copy in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge, completes the request |

## Verification
The hardest case to reach from the ports is a register write that arrives while a copy is in flight. The copy must also finish exactly as if that write had never happened. To get there, the stimulus has the memory model stretch each acknowledge by a random zero to two cycles. It then fires source, count and control writes, including a repeated start, right after launch. Random transfers also place addresses next to the 20-bit wrap in both directions and overlap the source and destination. These show that the written stream follows sequential copy order.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;
    localparam int ADDR_W   = 20;
    localparam int LEN_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int OFF_W    = 4;
    localparam int NUM_BANK = 8;
    localparam int LOW_W    = 16;
    localparam int HI_W     = ADDR_W - LOW_W;

    localparam logic [OFF_W-1:0] OFF_SRC_LO  = 4'd0;
    localparam logic [OFF_W-1:0] OFF_SRC_MID = 4'd1;
    localparam logic [OFF_W-1:0] OFF_SRC_HI  = 4'd2;
    localparam logic [OFF_W-1:0] OFF_DST_HI  = 4'd3;
    localparam logic [OFF_W-1:0] OFF_DST_LO  = 4'd4;
    localparam logic [OFF_W-1:0] OFF_DST_MID = 4'd5;
    localparam logic [OFF_W-1:0] OFF_LEN_LO  = 4'd6;
    localparam logic [OFF_W-1:0] OFF_LEN_HI  = 4'd7;
    localparam logic [OFF_W-1:0] OFF_CTRL    = 4'd8;

    localparam int CTRL_GO  = 7;
    localparam int CTRL_DIR = 0;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef struct packed {
        addr_t src;
        addr_t dst;
        len_t  len;
        logic  down;
    } xfer_cfg_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_FETCH = 2'd1,
        ENG_STORE = 2'd2
    } eng_state_e;

    function automatic addr_t addr_step(input addr_t a, input logic down);
        return down ? (a - addr_t'(1)) : (a + addr_t'(1));
    endfunction
endpackage

// File: rtl/blkcopy_regs.sv
module blkcopy_regs
    import blkcopy_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [OFF_W-1:0]    wr_off,
    input  byte_t               wr_data,
    input  logic [OFF_W-1:0]    rd_off,
    output byte_t               rd_data,
    input  logic                busy_i,
    input  logic                done_i,
    input  logic [LOW_W-1:0]    fin_src_i,
    input  logic [LOW_W-1:0]    fin_dst_i,
    output logic                launch_o,
    output xfer_cfg_t           cfg_o
);
    logic [NUM_BANK-1:0][BYTE_W-1:0] bank_q;
    logic [BYTE_W-2:0]               ctrl_q;
    len_t                            len_now;
    logic                            go_write;
    logic                            idle_wr;

    assign len_now  = {bank_q[OFF_LEN_HI], bank_q[OFF_LEN_LO]};
    assign idle_wr  = wr_en && !busy_i;
    assign go_write = idle_wr && (wr_off == OFF_CTRL) && wr_data[CTRL_GO];
    assign launch_o = go_write && (len_now != '0);

    assign cfg_o.src  = {bank_q[OFF_SRC_HI][HI_W-1:0], bank_q[OFF_SRC_MID], bank_q[OFF_SRC_LO]};
    assign cfg_o.dst  = {bank_q[OFF_DST_HI][HI_W-1:0], bank_q[OFF_DST_MID], bank_q[OFF_DST_LO]};
    assign cfg_o.len  = len_now;
    assign cfg_o.down = wr_data[CTRL_DIR];

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
            ctrl_q <= '0;
        end else if (done_i) begin
            bank_q[OFF_SRC_LO]  <= fin_src_i[7:0];
            bank_q[OFF_SRC_MID] <= fin_src_i[15:8];
            bank_q[OFF_DST_LO]  <= fin_dst_i[7:0];
            bank_q[OFF_DST_MID] <= fin_dst_i[15:8];
            bank_q[OFF_LEN_LO]  <= '0;
            bank_q[OFF_LEN_HI]  <= '0;
            ctrl_q              <= '0;
        end else if (idle_wr) begin
            for (int i = 0; i < NUM_BANK; i++) begin
                if (wr_off == OFF_W'(i)) bank_q[i] <= wr_data;
            end
            if (wr_off == OFF_CTRL) begin
                ctrl_q <= (wr_data[CTRL_GO] && len_now == '0) ? '0 : wr_data[BYTE_W-2:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_off == OFF_CTRL)
            rd_data = {busy_i, ctrl_q};
        else if (rd_off < OFF_W'(NUM_BANK))
            rd_data = bank_q[rd_off[2:0]];
    end

    // R9
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && wr_en && !done_i) |=> ($stable(bank_q) && $stable(ctrl_q)));

    // R6
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        done_i |=> (len_now == '0 && ctrl_q == '0));

    // R8
    zero_start_chk: assert property (@(posedge clk) disable iff (rst)
        (go_write && len_now == '0) |=> (ctrl_q == '0 && !busy_i));
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
    import blkcopy_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             launch_i,
    input  xfer_cfg_t        cfg_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [LOW_W-1:0] fin_src_o,
    output logic [LOW_W-1:0] fin_dst_o,
    output logic             mem_req,
    output logic             mem_we,
    output addr_t            mem_addr,
    output byte_t            mem_wdata,
    input  byte_t            mem_rdata,
    input  logic             mem_ack
);
    eng_state_e state_q;
    addr_t      src_q, dst_q, src_nxt, dst_nxt;
    len_t       left_q;
    logic       down_q;
    byte_t      hold_q;
    logic       last_step;

    assign src_nxt   = addr_step(src_q, down_q);
    assign dst_nxt   = addr_step(dst_q, down_q);
    assign last_step = (left_q == len_t'(1));

    assign busy_o    = (state_q != ENG_IDLE);
    assign mem_req   = busy_o;
    assign mem_we    = (state_q == ENG_STORE);
    assign mem_addr  = mem_we ? dst_q : src_q;
    assign mem_wdata = hold_q;
    assign done_o    = (state_q == ENG_STORE) && mem_ack && last_step;
    assign fin_src_o = src_nxt[LOW_W-1:0];
    assign fin_dst_o = dst_nxt[LOW_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            src_q   <= '0;
            dst_q   <= '0;
            left_q  <= '0;
            down_q  <= 1'b0;
            hold_q  <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: if (launch_i) begin
                    src_q   <= cfg_i.src;
                    dst_q   <= cfg_i.dst;
                    left_q  <= cfg_i.len;
                    down_q  <= cfg_i.down;
                    state_q <= ENG_FETCH;
                end
                ENG_FETCH: if (mem_ack) begin
                    hold_q  <= mem_rdata;
                    state_q <= ENG_STORE;
                end
                ENG_STORE: if (mem_ack) begin
                    src_q   <= src_nxt;
                    dst_q   <= dst_nxt;
                    left_q  <= left_q - len_t'(1);
                    state_q <= last_step ? ENG_IDLE : ENG_FETCH;
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R4
    read_then_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && mem_wdata == $past(mem_rdata)));

    // R5
    src_walk_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack && !last_step) |=>
            (mem_addr == addr_step($past(src_q), down_q)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mem_req);
endmodule

// File: rtl/blkcopy_dma.sv
module blkcopy_dma
    import blkcopy_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [3:0]  reg_wr_off,
    input  logic [7:0]  reg_wr_data,
    input  logic [3:0]  reg_rd_off,
    output logic [7:0]  reg_rd_data,
    output logic        busy,
    output logic        mem_req,
    output logic        mem_we,
    output logic [19:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    input  logic        mem_ack
);
    xfer_cfg_t        cfg;
    logic             launch;
    logic             done;
    logic [LOW_W-1:0] fin_src, fin_dst;

    blkcopy_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .wr_off    (reg_wr_off),
        .wr_data   (reg_wr_data),
        .rd_off    (reg_rd_off),
        .rd_data   (reg_rd_data),
        .busy_i    (busy),
        .done_i    (done),
        .fin_src_i (fin_src),
        .fin_dst_i (fin_dst),
        .launch_o  (launch),
        .cfg_o     (cfg)
    );

    blkcopy_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .launch_i  (launch),
        .cfg_i     (cfg),
        .busy_o    (busy),
        .done_o    (done),
        .fin_src_o (fin_src),
        .fin_dst_o (fin_dst),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack)
    );

    // R3
    launch_busy_chk: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy);
endmodule

// File: tb/blkcopy_dma_bench.sv
module blkcopy_dma_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_wr_off = '0;
    logic [7:0]  reg_wr_data = '0;
    logic [3:0]  reg_rd_off = '0;
    logic [7:0]  reg_rd_data;
    logic        busy;
    logic        mem_req;
    logic        mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #2 clk = ~clk;

    blkcopy_dma u_blkcopy_dma (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_off(reg_wr_off), .reg_wr_data(reg_wr_data),
        .reg_rd_off(reg_rd_off), .reg_rd_data(reg_rd_data), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int n_chk = 0;
    int n_bad = 0;
    int acc_cnt = 0;
    int ack_wait = 0;
    logic [7:0] dut_mem [int];
    logic [7:0] exp_mem [int];
    int   wq_addr[$];
    logic [7:0] wq_data[$];
    int   eq_addr[$];
    logic [7:0] eq_data[$];

    function automatic logic [7:0] pat(input int a);
        logic [19:0] x;
        x = a[19:0];
        return x[7:0] ^ {x[11:8], x[15:12]} ^ {x[19:16], 4'h9} ^ 8'h3C;
    endfunction

    function automatic logic [7:0] dut_get(input int a);
        return dut_mem.exists(a) ? dut_mem[a] : pat(a);
    endfunction

    function automatic logic [7:0] exp_get(input int a);
        return exp_mem.exists(a) ? exp_mem[a] : pat(a);
    endfunction

    function automatic logic [19:0] stepa(input logic [19:0] a, input bit down);
        return down ? a - 20'd1 : a + 20'd1;
    endfunction

    // memory model: random acknowledge delay, writes/reads act at the ack
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            ack_wait = $urandom % 3;
        end else if (mem_req) begin
            if (ack_wait == 0) begin
                mem_ack = 1'b1;
                acc_cnt++;
                if (mem_we) begin
                    dut_mem[int'(mem_addr)] = mem_wdata;
                    wq_addr.push_back(int'(mem_addr));
                    wq_data.push_back(mem_wdata);
                end else begin
                    mem_rdata = dut_get(int'(mem_addr));
                end
            end else begin
                ack_wait--;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] off, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_off = off; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] off, output logic [7:0] d);
        reg_rd_off = off;
        #1;
        d = reg_rd_data;
    endtask

    task automatic wait_idle();
        logic [7:0] c;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            reg_read(4'd8, c);
            if (!c[7]) break;
        end
    endtask

    task automatic run_xfer(input logic [19:0] src, input logic [19:0] dst,
                            input logic [15:0] len, input bit down, input bit poke);
        logic [7:0] shi, dhi, v;
        logic [19:0] s, d;
        int bad;
        shi = {4'($urandom), src[19:16]};
        dhi = {4'($urandom), dst[19:16]};
        wq_addr.delete(); wq_data.delete(); eq_addr.delete(); eq_data.delete();
        s = src; d = dst;
        for (int i = 0; i < int'(len); i++) begin
            v = exp_get(int'(s));
            exp_mem[int'(d)] = v;
            eq_addr.push_back(int'(d)); eq_data.push_back(v);
            s = stepa(s, down); d = stepa(d, down);
        end
        reg_write(4'd0, src[7:0]);  reg_write(4'd1, src[15:8]); reg_write(4'd2, shi);
        reg_write(4'd3, dhi);       reg_write(4'd4, dst[7:0]);  reg_write(4'd5, dst[15:8]);
        reg_write(4'd6, len[7:0]);  reg_write(4'd7, len[15:8]);
        reg_write(4'd8, {1'b1, 6'($urandom), down});
        reg_read(4'd8, v);
        chk(v[7] == 1'b1 && busy, "R3 busy after start", longint'(v), 8'h80);
        if (poke) begin
            reg_write(4'd0, 8'hEE);
            reg_write(4'd6, 8'h33);
            reg_write(4'd8, 8'h81);
        end
        wait_idle();
        chk(!busy, "R6 busy low at end", longint'(busy), 0);
        chk(wq_addr.size() == eq_addr.size(), "R4 write count", wq_addr.size(), eq_addr.size());
        bad = 0;
        for (int i = 0; i < eq_addr.size() && i < wq_addr.size(); i++)
            if (wq_addr[i] != eq_addr[i] || wq_data[i] != eq_data[i]) bad++;
        chk(bad == 0, down ? "R5 R4 descending stream" : "R5 R4 ascending stream", bad, 0);
        reg_read(4'd6, v); chk(v == 8'h00, "R6 count low cleared", v, 0);
        reg_read(4'd7, v); chk(v == 8'h00, "R6 count high cleared", v, 0);
        reg_read(4'd8, v); chk(v == 8'h00, "R6 control cleared", v, 0);
        reg_read(4'd0, v); chk(v == s[7:0], "R6 source bits 7:0", v, s[7:0]);
        reg_read(4'd1, v); chk(v == s[15:8], "R6 source bits 15:8", v, s[15:8]);
        reg_read(4'd4, v); chk(v == d[7:0], "R6 destination bits 7:0", v, d[7:0]);
        reg_read(4'd5, v); chk(v == d[15:8], "R6 destination bits 15:8", v, d[15:8]);
        reg_read(4'd2, v); chk(v == shi, "R7 source high byte kept", v, shi);
        reg_read(4'd3, v); chk(v == dhi, "R7 destination high byte kept", v, dhi);
        if (poke) chk(bad == 0 && wq_addr.size() == int'(len), "R9 writes while busy ignored",
                      wq_addr.size(), len);
    endtask

    initial begin
        logic [7:0] v;
        int a0;
        void'($urandom(32'd77));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int o = 0; o < 9; o++) begin
            reg_read(4'(o), v);
            chk(v == 8'h00, "R1 register reset", v, 0);
        end
        chk(!busy && !mem_req, "R1 idle outputs", {busy, mem_req}, 0);

        // R2 readback while idle
        reg_write(4'd2, 8'hA7); reg_read(4'd2, v); chk(v == 8'hA7, "R2 readback offset 2", v, 8'hA7);
        reg_write(4'd5, 8'h5C); reg_read(4'd5, v); chk(v == 8'h5C, "R2 readback offset 5", v, 8'h5C);
        reg_write(4'd8, 8'h45); reg_read(4'd8, v); chk(v == 8'h45, "R2 control without go", v, 8'h45);
        chk(!mem_req, "R2 no access without go", mem_req, 0);

        // R8 zero count start
        reg_write(4'd6, 8'h00); reg_write(4'd7, 8'h00);
        a0 = acc_cnt;
        reg_write(4'd8, 8'h81);
        reg_read(4'd8, v); chk(v == 8'h00, "R8 zero count control", v, 0);
        chk(!busy, "R8 zero count not busy", busy, 0);
        repeat (10) @(negedge clk);
        chk(acc_cnt == a0, "R8 zero count no access", acc_cnt, a0);

        // directed corners
        run_xfer(20'h01000, 20'h02000, 16'd1, 1'b0, 1'b0);
        run_xfer(20'hFFFFD, 20'h3FFFE, 16'd6, 1'b0, 1'b0);   // wrap upward
        run_xfer(20'h00002, 20'h10001, 16'd5, 1'b1, 1'b0);   // wrap downward
        run_xfer(20'h05000, 20'h05002, 16'd7, 1'b0, 1'b0);   // overlapping forward
        run_xfer(20'h06005, 20'h06003, 16'd7, 1'b1, 1'b0);   // overlapping backward
        run_xfer(20'h08100, 20'h09200, 16'd12, 1'b0, 1'b1);  // R9 pokes during busy
        run_xfer(20'h0A1FF, 20'h0B0FF, 16'd9, 1'b1, 1'b1);

        // random transfers
        for (int k = 0; k < 20; k++) begin
            run_xfer(20'($urandom), 20'($urandom), 16'(1 + $urandom % 40),
                     1'($urandom), 1'($urandom % 4 == 0));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule